// File: doc/BRIEF.md
# Segmented Memory Access Fault Checker

This block checks one segmented memory access before address translation. Each request carries:

- the kind of segment being used;
- the selector, base, limit and writable attribute of that segment;
- the 64-bit offset, the access size and a read/write flag;
- the processor mode bits that affect the checks.

The block decides whether the access must be refused and with which fault. If the access is allowed, it forms the linear address that the paging stage will translate.

The kind of segment and the processor mode decide which test applies.

- A code or data segment is tested against its limit outside 64-bit mode and for a canonical address inside it.
- The stack segment is tested the same way but reports a stack fault.
- Descriptor and task tables are always tested against their limit. When long mode is active they are also tested for a canonical address.
- A null selector, a write to a read-only segment and a misaligned access under alignment checking are tested around these, in a fixed priority.

The answer is registered. It appears one cycle after the request, together with a valid flag. Exactly one fault code is reported, or else the linear address.

Top module: `seg_access_guard`

## Requirements
- R1: A request whose selector has bits 15:2 all zero reports fault code 1 (general protection). This test has the highest priority, whatever the other inputs are.
- R2: If R1 does not apply, a request with the write flag set to a segment whose writable input is 0 reports fault code 1.
- R3: For segment kinds 0 to 4 (code, data, extra, F and G segments), later in priority than R2:
  - in 64-bit mode (long-mode active = 1, code L bit = 1, code D bit = 0), an offset whose bits 63:47 are not all equal reports fault code 1, and the limit is not used;
  - outside 64-bit mode, an offset greater than the zero-extended limit reports fault code 1.
- R4: For segment kind 5 (stack), the same conditions as in R3 report fault code 2 (stack fault) instead.
- R5: For segment kinds 6 to 15, which are all treated as system tables, later in priority than R2:
  - an offset greater than the limit reports fault code 1 in every mode;
  - a non-canonical offset reports fault code 1 whenever long-mode active is 1.
- R6: Alignment checking is enabled only when the alignment-mask bit is 1, the flag AC bit is 1 and the privilege level is 3. When it is enabled and no earlier fault applies, an offset that is not a multiple of 2^size reports fault code 3. Size code 0..3 means 1, 2, 4 or 8 bytes. When alignment checking is not enabled, fault code 3 is never reported.
- R7: With no fault (code 0), the linear address depends on the mode and the segment kind:
  - in 64-bit mode with segment kind 0, 1, 2 or 5, it equals the offset;
  - otherwise it is base plus offset, modulo 2^64.
- R8: The valid output follows the request valid by exactly one cycle. A reported fault gives a linear address of zero. A cycle without a request gives valid, fault and linear all zero one cycle later.
- R9: While reset is asserted and in the first cycle after it, valid, fault and linear read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 4 | Segment kind code (0 code, 1 data, 2 extra, 3 F, 4 G, 5 stack, 6..15 system table) |
| req_sel | input | 16 | Segment selector |
| req_base | input | 64 | Segment base address |
| req_limit | input | 32 | Segment limit, highest valid offset |
| req_writable | input | 1 | Segment permits writes |
| req_offset | input | 64 | Effective offset of the access |
| req_size | input | 2 | Access size as log2 of the byte count |
| req_write | input | 1 | 1 for a write, 0 for a read |
| mode_lma | input | 1 | Long mode active |
| mode_cs_l | input | 1 | Code segment L bit |
| mode_cs_d | input | 1 | Code segment D bit |
| mode_am | input | 1 | Alignment mask control bit |
| mode_ac | input | 1 | Alignment check flag bit |
| mode_cpl | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 2 | 0 none, 1 general protection, 2 stack fault, 3 alignment |
| rsp_linear | output | 64 | Linear address, zero when a fault is reported |

## Verification
The hardest case to produce is one where two or three tests fail together, so that only the priority order decides which fault is seen. An example is a misaligned offset that is also past the limit, sent to a read-only stack segment in compatibility mode. Another is a high canonical offset that passes in 64-bit mode but breaks the limit of a system table.

The bench reaches these cases with a full cross product. It crosses all ten segment kinds, all eight mode-bit combinations, null and non-null selectors, every writable/write pair, and eight offsets placed on and around the limit and the canonical boundary. It also covers every access size and four alignment-enable settings. The expected fault and address for each case are computed from the priority rules.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

   typedef enum logic [3:0] {
      SK_CODE  = 4'd0,
      SK_DATA  = 4'd1,
      SK_EXTRA = 4'd2,
      SK_FSEG  = 4'd3,
      SK_GSEG  = 4'd4,
      SK_STACK = 4'd5,
      SK_DTAB  = 4'd6,
      SK_LTAB  = 4'd7,
      SK_ITAB  = 4'd8,
      SK_TASK  = 4'd9
   } seg_kind_e;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_PROT  = 2'd1,
      FLT_STACK = 2'd2,
      FLT_ALIGN = 2'd3
   } fault_e;

   // kinds from the descriptor tables upward are treated as system tables
   function automatic logic kind_is_table(input logic [3:0] k);
      return k >= SK_DTAB;
   endfunction

   // kinds whose base is ignored in 64-bit mode
   function automatic logic kind_is_flat(input logic [3:0] k);
      return (k == SK_CODE) || (k == SK_DATA) || (k == SK_EXTRA) || (k == SK_STACK);
   endfunction

endpackage

// File: rtl/sg_canon.sv
module sg_canon #(
   parameter int OFF_W   = 64,
   parameter int VA_BITS = 48
) (
   input  logic [OFF_W-1:0] offset,
   output logic             canonical
);
   localparam int TOP_N = OFF_W - VA_BITS + 1;

   generate
      if (VA_BITS > OFF_W || VA_BITS < 2) begin : g_bad
         $error("sg_canon: VA_BITS must lie in 2..OFF_W");
      end
      if (VA_BITS == OFF_W) begin : g_full
         // every offset is a valid address when the address space is full width
         assign canonical = 1'b1;
      end else begin : g_sext
         logic [TOP_N-1:0] upper;
         assign upper     = offset[OFF_W-1:VA_BITS-1];
         assign canonical = (&upper) | ~(|upper);
      end
   endgenerate
endmodule

// File: rtl/sg_align.sv
module sg_align #(
   parameter int OFF_W  = 64,
   parameter int SIZE_W = 2
) (
   input  logic [OFF_W-1:0]  offset,
   input  logic [SIZE_W-1:0] size_log2,
   input  logic              enable,
   output logic              misaligned
);
   localparam int MASK_W = (1 << SIZE_W) - 1;

   generate
      if (SIZE_W < 1 || MASK_W >= OFF_W) begin : g_bad
         $error("sg_align: SIZE_W out of range for OFF_W");
      end
   endgenerate

   logic [MASK_W-1:0] low_mask;

   always_comb begin
      for (int i = 0; i < MASK_W; i++) begin
         low_mask[i] = (i < int'(size_log2));
      end
   end

   assign misaligned = enable & (|(offset[MASK_W-1:0] & low_mask));
endmodule

// File: rtl/sg_classify.sv
module sg_classify
   import seg_guard_pkg::*;
#(
   parameter int OFF_W = 64,
   parameter int LIM_W = 32,
   parameter int SEL_W = 16
) (
   input  logic [3:0]       kind,
   input  logic [SEL_W-1:0] sel,
   input  logic [OFF_W-1:0] base,
   input  logic [LIM_W-1:0] limit,
   input  logic             writable,
   input  logic             is_write,
   input  logic [OFF_W-1:0] offset,
   input  logic             long_act,
   input  logic             mode64,
   input  logic             canonical,
   input  logic             misaligned,
   output fault_e           fault,
   output logic [OFF_W-1:0] linear
);
   generate
      if (LIM_W > OFF_W || SEL_W < 3) begin : g_bad
         $error("sg_classify: LIM_W must not exceed OFF_W and SEL_W must exceed 2");
      end
   endgenerate

   logic   null_sel;
   logic   ro_write;
   logic   over_lim;
   logic   bound_bad;
   fault_e bound_code;

   assign null_sel = ~(|sel[SEL_W-1:2]);
   assign ro_write = is_write & ~writable;
   assign over_lim = offset > OFF_W'(limit);

   // kind- and mode-dependent boundary test
   always_comb begin
      if (kind_is_table(kind)) begin
         bound_bad  = over_lim | (long_act & ~canonical);
         bound_code = FLT_PROT;
      end else begin
         bound_bad  = mode64 ? ~canonical : over_lim;
         bound_code = (kind == SK_STACK) ? FLT_STACK : FLT_PROT;
      end
   end

   // first failing test wins
   always_comb begin
      if (null_sel)        fault = FLT_PROT;
      else if (ro_write)   fault = FLT_PROT;
      else if (bound_bad)  fault = bound_code;
      else if (misaligned) fault = FLT_ALIGN;
      else                 fault = FLT_NONE;
   end

   assign linear = (mode64 && kind_is_flat(kind)) ? offset : base + offset;
endmodule

// File: rtl/seg_access_guard.sv
module seg_access_guard
   import seg_guard_pkg::*;
#(
   parameter int OFF_W   = 64,
   parameter int LIM_W   = 32,
   parameter int SEL_W   = 16,
   parameter int SIZE_W  = 2,
   parameter int VA_BITS = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [3:0]        req_kind,
   input  logic [SEL_W-1:0]  req_sel,
   input  logic [OFF_W-1:0]  req_base,
   input  logic [LIM_W-1:0]  req_limit,
   input  logic              req_writable,
   input  logic [OFF_W-1:0]  req_offset,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              req_write,
   input  logic              mode_lma,
   input  logic              mode_cs_l,
   input  logic              mode_cs_d,
   input  logic              mode_am,
   input  logic              mode_ac,
   input  logic [1:0]        mode_cpl,
   output logic              rsp_valid,
   output logic [1:0]        rsp_fault,
   output logic [OFF_W-1:0]  rsp_linear
);
   logic             mode64;
   logic             align_en;
   logic             canonical;
   logic             misaligned;
   fault_e           fault_c;
   logic [OFF_W-1:0] linear_c;

   assign mode64   = mode_lma & mode_cs_l & ~mode_cs_d;
   assign align_en = mode_am & mode_ac & (mode_cpl == 2'd3);

   sg_canon #(.OFF_W(OFF_W), .VA_BITS(VA_BITS)) u_canon (
      .offset    (req_offset),
      .canonical (canonical)
   );

   sg_align #(.OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_align (
      .offset     (req_offset),
      .size_log2  (req_size),
      .enable     (align_en),
      .misaligned (misaligned)
   );

   sg_classify #(.OFF_W(OFF_W), .LIM_W(LIM_W), .SEL_W(SEL_W)) u_class (
      .kind       (req_kind),
      .sel        (req_sel),
      .base       (req_base),
      .limit      (req_limit),
      .writable   (req_writable),
      .is_write   (req_write),
      .offset     (req_offset),
      .long_act   (mode_lma),
      .mode64     (mode64),
      .canonical  (canonical),
      .misaligned (misaligned),
      .fault      (fault_c),
      .linear     (linear_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_fault  <= FLT_NONE;
         rsp_linear <= '0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_fault  <= req_valid ? fault_c : FLT_NONE;
         rsp_linear <= (req_valid && fault_c == FLT_NONE) ? linear_c : '0;
      end
   end

   a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && rsp_fault == 2'd0 && rsp_linear == '0));

   a_r8_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault != 2'd0) |-> (rsp_linear == '0));

   a_r1_null_first: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_sel[SEL_W-1:2] == '0) |=> (rsp_fault == 2'd1));

   a_r2_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !req_writable) |=> (rsp_fault == 2'd1));

   a_r6_align_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !(mode_am && mode_ac && mode_cpl == 2'd3)) |=> (rsp_fault != 2'd3));

   a_r4_stack_only: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault == 2'd2) |-> ($past(req_kind) == 4'd5));
endmodule

// File: tb/seg_access_guard_test.sv
`timescale 1ns/1ps
module seg_access_guard_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_kind = '0;
   logic [15:0] req_sel = '0;
   logic [63:0] req_base = '0;
   logic [31:0] req_limit = '0;
   logic        req_writable = 1'b0;
   logic [63:0] req_offset = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic        mode_lma = 1'b0, mode_cs_l = 1'b0, mode_cs_d = 1'b0;
   logic        mode_am = 1'b0, mode_ac = 1'b0;
   logic [1:0]  mode_cpl = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_fault;
   logic [63:0] rsp_linear;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   seg_access_guard uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_sel(req_sel), .req_base(req_base), .req_limit(req_limit),
      .req_writable(req_writable), .req_offset(req_offset), .req_size(req_size),
      .req_write(req_write), .mode_lma(mode_lma), .mode_cs_l(mode_cs_l),
      .mode_cs_d(mode_cs_d), .mode_am(mode_am), .mode_ac(mode_ac),
      .mode_cpl(mode_cpl), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
      .rsp_linear(rsp_linear)
   );

   localparam logic [63:0] BASE  = 64'h0000_0012_3400_0000;
   localparam logic [31:0] LIMIT = 32'h0000_1000;

   function automatic logic [63:0] pick_offset(input int p);
      case (p)
         0: return 64'h0000_0000_0000_0800;
         1: return 64'h0000_0000_0000_0803;
         2: return 64'h0000_0000_0000_1000;
         3: return 64'h0000_0000_0000_1001;
         4: return 64'h0000_0000_0000_2000;
         5: return 64'h0000_8000_0000_0000;
         6: return 64'hFFFF_8000_0000_0004;
         default: return 64'h0000_7FFF_FFFF_FFFE;
      endcase
   endfunction

   // expected result from the requirement rules
   task automatic expect_of(output logic [1:0] f, output logic [63:0] lin, output string tag);
      logic b64, over, canon, acen, flat;
      b64   = mode_lma & mode_cs_l & ~mode_cs_d;
      over  = req_offset > {32'd0, req_limit};
      canon = (req_offset[63:47] == 17'h1FFFF) || (req_offset[63:47] == 17'h0);
      acen  = mode_am && mode_ac && mode_cpl == 2'd3;
      flat  = b64 && (req_kind == 0 || req_kind == 1 || req_kind == 2 || req_kind == 5);
      lin = 64'd0;
      if (req_sel[15:2] == 14'd0) begin
         f = 2'd1; tag = "R1";
      end else if (req_write && !req_writable) begin
         f = 2'd1; tag = "R2";
      end else if (req_kind >= 4'd6 && (over || (mode_lma && !canon))) begin
         f = 2'd1; tag = "R5";
      end else if (req_kind < 4'd6 && (b64 ? !canon : over)) begin
         if (req_kind == 4'd5) begin f = 2'd2; tag = "R4"; end
         else begin f = 2'd1; tag = "R3"; end
      end else if (acen && ((req_offset & ((64'd1 << req_size) - 64'd1)) != 64'd0)) begin
         f = 2'd3; tag = "R6";
      end else begin
         f = 2'd0; tag = "R7";
         lin = flat ? req_offset : req_base + req_offset;
      end
   endtask

   task automatic check(input string tag, input logic v, input logic [1:0] f,
                        input logic [63:0] lin);
      checks++;
      if (rsp_valid !== v || rsp_fault !== f || rsp_linear !== lin) begin
         fails++;
         $display("FAIL %s: got valid=%0b fault=%0d linear=%h, expected valid=%0b fault=%0d linear=%h",
                  tag, rsp_valid, rsp_fault, rsp_linear, v, f, lin);
      end
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(20.0 * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
   end

   initial begin
      logic [1:0]  ef;
      logic [63:0] el;
      string       tag;
      repeat (3) @(negedge clk);
      check("R9 reset", 1'b0, 2'd0, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #5;
      check("R9 after reset", 1'b0, 2'd0, 64'd0);
      req_base  = BASE;
      req_limit = LIMIT;
      for (int k = 0; k < 10; k++)
      for (int m = 0; m < 8; m++)
      for (int n = 0; n < 2; n++)
      for (int w = 0; w < 4; w++)
      for (int p = 0; p < 8; p++)
      for (int s = 0; s < 4; s++)
      for (int a = 0; a < 4; a++) begin
         @(negedge clk);
         req_valid    = 1'b1;
         req_kind     = 4'(k);
         mode_lma     = m[2];
         mode_cs_l    = m[1];
         mode_cs_d    = m[0];
         req_sel      = n[0] ? 16'h0003 : 16'h0010;
         req_writable = w[1];
         req_write    = w[0];
         req_offset   = pick_offset(p);
         req_size     = 2'(s);
         mode_am      = (a != 2);
         mode_ac      = (a != 3);
         mode_cpl     = (a == 1) ? 2'd2 : 2'd3;
         expect_of(ef, el, tag);
         @(posedge clk); #5;
         check(tag, 1'b1, ef, el);
      end
      // base wrap with a flat-excluded kind in 64-bit mode (R7)
      @(negedge clk);
      req_kind = 4'd3; req_sel = 16'h0018; req_writable = 1'b1; req_write = 1'b0;
      mode_lma = 1'b1; mode_cs_l = 1'b1; mode_cs_d = 1'b0; mode_am = 1'b0;
      req_base = 64'hFFFF_FFFF_FFFF_FFF0; req_offset = 64'h0000_0000_0000_0020;
      @(posedge clk); #5;
      check("R7 base wrap", 1'b1, 2'd0, 64'h0000_0000_0000_0010);
      // idle cycle (R8)
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk); #5;
      check("R8 idle", 1'b0, 2'd0, 64'd0);
      finish_run();
   end
endmodule